// File: doc/BRIEF.md
# HDLC Bit Serializer with Zero Insertion

This block is the bit-level stage of an HDLC transmit path. An upper sequencer hands it one byte at a time. The block shifts that byte out serially, one bit per rising edge of the transmit clock. Within frame content, it adds a 0 after any five 1s in a row, so that the line never carries the flag pattern by accident. A per-byte control input turns the insertion off, so the sequencer can send flags and aborts through the same path.

The serializer runs as an explicit state machine with these states: an idle state, one state per data bit, and an insertion state. A counter of consecutive 1s decides when to take the detour through the insertion state. The counter keeps its value across byte boundaries, so a run of 1s that spans two bytes is still broken. While no data is waiting, the line rests at 1.

The request output tells the sequencer when to supply the next byte. It is high while the serializer is idle, and high for one cycle at the close of each byte. The byte on the input is taken at the clock edge where the request and the valid input are both high. If a byte is ready at that moment, bytes follow each other on the line with no gap.

Top module: `hdlc_bit_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, the line output is 1 and the request output is 1.
- R2: In idle with no valid byte, the line stays at 1, the request stays at 1 and the serializer stays idle.
- R3: A taken byte is sent one bit per clock, bit 0 first, starting in the cycle after it was taken. A byte taken at the close of the previous byte follows that byte with no idle gap.
- R4: With insertion enabled, the line carries exactly one 0 right after the fifth consecutive 1, and then continues with the next bit of the byte.
- R5: The count of consecutive 1s carries across byte boundaries. Five 1s spread over two adjacent bytes therefore produce an insertion.
- R6: A byte taken with the stuff-disable input high is sent unaltered, with no insertion. The count restarts from zero for the byte that follows it.
- R7: The request output is high for exactly one cycle at the close of each byte. That cycle is the last data bit, or the inserted 0 when an insertion follows bit 7. The byte input is sampled only at an edge where the request is high, and is ignored at all other edges.
- R8: When no byte is valid at the close of a byte, the serializer returns to idle and clears the count. A run of 1s does not carry across an idle period.
- R9: A 0 data bit clears the count of consecutive 1s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Upper layer has a byte ready on byte_data |
| byte_data | input | W | Byte to transmit, bit 0 sent first |
| stuff_off | input | 1 | Disable zero insertion for the byte being handed over |
| byte_req | output | 1 | Serializer will take a byte at the next edge |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench sweeps every byte value, sent twice in a row. This exposes runs of 1s that straddle the byte boundary: a design that reset its count per byte would let six 1s through, and one that resumed at the wrong bit after an insertion would repeat or drop a data bit. Dedicated sequences cover three further cases. The first is an insertion that lands after bit 7, where a design that raised the request during the last data bit instead of during the inserted 0 would lose a cycle of alignment. The second is an insertion-free byte between two stuffed bytes, where a leftover count would cause a spurious insertion. The third is a run of 1s that ends just before an idle period, where a count that survives idle would insert a 0 early in the next transfer. The byte input is kept valid with changing data while the request is low, so a design that sampled it outside the request window would send the wrong bytes.

// File: rtl/hdlc_ser_pkg.sv
package hdlc_ser_pkg;

  // Next value of the consecutive-ones count after one data bit.
  function automatic int unsigned ones_next(input int unsigned cnt, input logic b,
                                            input logic hold);
    if (hold) return 0;
    if (b) return cnt + 1;
    return 0;
  endfunction

  // True when the bit now on the line completes a run that must be broken.
  function automatic logic stuff_due(input int unsigned cnt, input logic b,
                                     input logic hold, input int unsigned run_len);
    return !hold && b && (cnt == run_len - 1);
  endfunction

endpackage

// File: rtl/hdlc_ser_hold.sv
module hdlc_ser_hold #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  din,
  input  logic          stuff_off,
  input  logic [IW-1:0] sel,
  output logic          cur_bit,
  output logic          nostuff
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      nostuff <= 1'b0;
    end else if (load) begin
      data_q  <= din;
      nostuff <= stuff_off;
    end
  end

  assign cur_bit = data_q[sel];
endmodule

// File: rtl/hdlc_ser_run.sv
module hdlc_ser_run
  import hdlc_ser_pkg::*;
#(
  parameter int RUN = 5,
  localparam int CW = $clog2(RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_idle,
  input  logic          in_bit,
  input  logic          in_ins,
  input  logic          line_bit,
  input  logic          nostuff,
  input  logic          load_clr,
  output logic [CW-1:0] cnt,
  output logic          ins_due
);
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (in_idle || in_ins || load_clr) cnt_n = '0;
    else if (in_bit) cnt_n = CW'(ones_next(int'(cnt), line_bit, nostuff));
    else cnt_n = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else cnt <= cnt_n;
  end

  assign ins_due = in_bit && stuff_due(int'(cnt), line_bit, nostuff, RUN);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(RUN)); // R4
  AST_NOSTUFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && nostuff) |-> (cnt == '0)); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |=> (cnt == '0)); // R8
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && !line_bit) |=> (cnt == '0)); // R9
endmodule

// File: rtl/hdlc_ser_fsm.sv
module hdlc_ser_fsm #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1,
  localparam int PW = $clog2(W + 1),
  localparam int NS = W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          ins_due,
  output logic          in_idle,
  output logic          in_bit,
  output logic          in_ins,
  output logic [IW-1:0] idx,
  output logic          byte_end
);
  // one-hot: [0] idle, [1+k] data bit k, [W+1] insertion
  logic [NS-1:0] st, st_n;
  logic [PW-1:0] rpos, rpos_n;
  logic          resume_done;

  assign in_idle     = st[0];
  assign in_ins      = st[W+1];
  assign in_bit      = |st[W:1];
  assign resume_done = (rpos == PW'(W));

  always_comb begin
    idx = '0;
    for (int k = 0; k < W; k++)
      if (st[k+1]) idx = IW'(k);
  end

  assign byte_end = (st[W] && !ins_due) || (in_ins && resume_done);

  always_comb begin
    st_n   = '0;
    rpos_n = rpos;
    if (in_idle) begin
      if (take) st_n[1] = 1'b1;
      else      st_n[0] = 1'b1;
    end else if (in_ins) begin
      if (resume_done) begin
        if (take) st_n[1] = 1'b1;
        else      st_n[0] = 1'b1;
      end else begin
        st_n[int'(rpos) + 1] = 1'b1;
      end
    end else begin
      if (ins_due) begin
        st_n[W+1] = 1'b1;
        rpos_n    = PW'(idx) + PW'(1);
      end else if (int'(idx) != W - 1) begin
        st_n[int'(idx) + 2] = 1'b1;
      end else if (take) begin
        st_n[1] = 1'b1;
      end else begin
        st_n[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= NS'(1);
      rpos <= '0;
    end else begin
      st   <= st_n;
      rpos <= rpos_n;
    end
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(st)); // R3
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> !byte_end); // R7
  AST_INS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ins && !resume_done) |=> (in_bit && idx == $past(rpos[IW-1:0]))); // R4
  AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && !ins_due && !byte_end) |=> (in_bit && idx == $past(idx) + IW'(1))); // R3
endmodule

// File: rtl/hdlc_bit_serializer.sv
module hdlc_bit_serializer #(
  parameter int W   = 8,
  parameter int RUN = 5,
  localparam int IW = (W > 1) ? $clog2(W) : 1,
  localparam int CW = $clog2(RUN + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_valid,
  input  logic [W-1:0] byte_data,
  input  logic         stuff_off,
  output logic         byte_req,
  output logic         tx_bit
);
  logic          in_idle, in_bit, in_ins, byte_end, ins_due;
  logic          cur_bit, nostuff, take;
  logic [IW-1:0] idx;
  logic [CW-1:0] run_cnt;

  assign byte_req = in_idle || byte_end;
  assign take     = byte_req && byte_valid;

  hdlc_ser_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .ins_due(ins_due),
    .in_idle(in_idle), .in_bit(in_bit), .in_ins(in_ins),
    .idx(idx), .byte_end(byte_end)
  );

  hdlc_ser_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(take), .din(byte_data),
    .stuff_off(stuff_off), .sel(idx), .cur_bit(cur_bit), .nostuff(nostuff)
  );

  hdlc_ser_run #(.RUN(RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .in_idle(in_idle), .in_bit(in_bit),
    .in_ins(in_ins), .line_bit(cur_bit), .nostuff(nostuff),
    .load_clr(take && stuff_off), .cnt(run_cnt), .ins_due(ins_due)
  );

  always_comb begin
    if (in_idle)     tx_bit = 1'b1;
    else if (in_ins) tx_bit = 1'b0;
    else             tx_bit = cur_bit;
  end

  AST_INS_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ins |-> ($past(tx_bit) && !$past(nostuff) && $past(run_cnt) == CW'(RUN - 1))); // R4
  AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !byte_valid) |=> (byte_req && tx_bit)); // R8
endmodule

// File: tb/hdlc_bit_serializer_test.sv
module hdlc_bit_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'hA5;
  logic       stuff_off = 1'b0;
  logic       byte_req, tx_bit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] q_data [0:3];
  bit         q_nos  [0:3];
  bit         e_bit  [0:127];
  bit         e_req  [0:127];

  always #2 clk = ~clk;

  hdlc_bit_serializer uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .stuff_off(stuff_off), .byte_req(byte_req), .tx_bit(tx_bit)
  );

  task automatic check(input string tag, input int slot, input bit act_b, input bit exp_b,
                       input bit act_r, input bit exp_r);
    checks++;
    if (act_b !== exp_b || act_r !== exp_r) begin
      errors++;
      $display("FAIL %s slot %0d: actual bit=%0b req=%0b expected bit=%0b req=%0b",
               tag, slot, act_b, act_r, exp_b, exp_r);
    end
  endtask

  // Build the expected line from the byte list, then drive and compare.
  task automatic run_seq(input int nb, input string tag);
    int n = 0;
    int run = 0;
    int ptr = 0;
    bit prev_take = 0;
    e_bit[n] = 1; e_req[n] = 1; n++;               // idle slot where byte 0 is taken
    for (int b = 0; b < nb; b++) begin
      if (q_nos[b]) run = 0;
      for (int i = 0; i < 8; i++) begin
        bit v = q_data[b][i];
        e_bit[n] = v; e_req[n] = 0; n++;
        if (q_nos[b]) run = 0;
        else if (v) run++;
        else run = 0;
        if (run == 5) begin
          e_bit[n] = 0; e_req[n] = 0; n++;
          run = 0;
        end
      end
      e_req[n-1] = 1;
    end
    for (int k = 0; k < 2; k++) begin
      e_bit[n] = 1; e_req[n] = 1; n++;
    end
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      if (prev_take) ptr++;
      check(tag, s, tx_bit, e_bit[s], byte_req, e_req[s]);
      byte_valid = (ptr < nb);
      byte_data  = (ptr < nb) ? q_data[ptr] : 8'h5A;
      stuff_off  = (ptr < nb) ? q_nos[ptr] : 1'b1;
      prev_take  = byte_req && byte_valid;
    end
    byte_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", -1, tx_bit, 1'b1, byte_req, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, tx_bit, 1'b1, byte_req, 1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R2", k, tx_bit, 1'b1, byte_req, 1'b1);
    end

    // R3 R4 R5 R7 R9: every byte value sent twice back to back
    for (int v = 0; v < 256; v++) begin
      q_data[0] = 8'(v); q_nos[0] = 0;
      q_data[1] = 8'(v); q_nos[1] = 0;
      run_seq(2, "R3/R5/R9 sweep");
    end

    q_data[0] = 8'hFF; q_nos[0] = 0; q_data[1] = 8'hFF; q_nos[1] = 0;
    run_seq(2, "R4 all ones");
    q_data[0] = 8'hF8; q_nos[0] = 0; q_data[1] = 8'h00; q_nos[1] = 0;
    run_seq(2, "R7 insertion after bit 7");
    q_data[0] = 8'hE0; q_nos[0] = 0; q_data[1] = 8'h03; q_nos[1] = 0;
    run_seq(2, "R5 run across boundary");
    q_data[0] = 8'h1F; q_nos[0] = 0; q_data[1] = 8'hFF; q_nos[1] = 1;
    q_data[2] = 8'h1F; q_nos[2] = 0;
    run_seq(3, "R6 unstuffed byte");
    q_data[0] = 8'h7E; q_nos[0] = 1; q_data[1] = 8'hFF; q_nos[1] = 0;
    q_data[2] = 8'h7E; q_nos[2] = 1;
    run_seq(3, "R6 flags around data");
    q_data[0] = 8'hF0; q_nos[0] = 0;
    run_seq(1, "R8 run before idle");
    q_data[0] = 8'h01; q_nos[0] = 0;
    run_seq(1, "R8 fresh after idle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R3: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule